// File: doc/BRIEF.md
# Configuration Session Controller

This block is the top-level state machine that runs one configuration session of a programmable device. It holds the device in reset while supply power is not good, or while the program pin is held low for long enough. Once out of reset, it runs a memory-clear phase and then waits on the shared open-drain init line. When that line reads high, it captures the configuration mode and the variant-select pin. It then passes incoming configuration words to the downstream frame loader. In master modes it also generates the configuration clock itself.

The init line carries three meanings. The controller pulls it low while clearing. An outside agent can hold it low to stall the session before the mode is captured. The controller pulls it low again to signal a frame CRC failure, and that failure ends the session. A failed session is left only through a new program pulse or a power cycle. When the frame loader reports that loading is complete, the controller releases the I/O tri-state control to the startup logic.

Top module: `cfg_session_ctrl`

## Requirements
- R1: While `pwrGood` is low, the outputs take their reset values at once (asynchronously): `initDriveLow`=1, `ioTristate`=1, `memClear`=0, `cclkEn`=0, `cclkOut`=0, `wordValid`=0.
- R2: The program pin is synchronized through two flops. A low level lasting at least MIN_PROG clocks restarts the session from any state: the controller holds reset and then starts clearing once the pin is high again. A low level lasting MIN_PROG-1 clocks or less is ignored.
- R3: Each session begins with exactly CLEAR_CYCLES cycles of `memClear`=1. During these cycles `initDriveLow`=1 and `ioTristate`=1.
- R4: After clearing, `initDriveLow` goes to 0. While the init line reads low because an outside agent holds it, the controller stays in the waiting state: it does not capture the mode and it keeps `cclkEn` low.
- R5: When the synchronized init line reads high in the waiting state, `cfgMode` captures `modePins`. The encoding is 00 master serial flash, 01 master parallel flash, 10 slave parallel, 11 slave serial. `cfgVariant` captures `variantSel` only for codes 00 and 01; otherwise it is 0. Both outputs hold their values until the next capture.
- R6: While loading in a master mode (code bit 1 = 0), `cclkEn`=1 and `cclkOut` toggles every CCLK_HALF clocks. In slave modes, `cclkEn`=0 and `cclkOut`=0.
- R7: While loading, a word on `dataIn` with `dataValid`=1 is passed to `wordOut`, and `wordValid` pulses for one cycle. In master modes, a word is taken only in the clock cycle where `cclkOut` rises. In slave modes, every valid word appears on the next cycle.
- R8: When `crcValid`=1 with `crcOk`=0 during loading, the session aborts. `initDriveLow` goes to 1, `cclkEn` goes to 0 and no further words are passed. This state persists until R2 or R1 applies.
- R9: When `loadDone`=1 during loading, `ioTristate` goes to 0 and `cclkEn` goes to 0.
- R10: If a CRC failure and `loadDone` arrive in the same cycle, the abort of R8 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwrGood | input | 1 | Supply good; low is an asynchronous reset |
| progPinN | input | 1 | Program pin, active low, asynchronous |
| initPinIn | input | 1 | Readback of the open-drain init line |
| modePins | input | 2 | Configuration mode select |
| variantSel | input | 1 | Variant select for master flash modes |
| dataIn | input | WORD_W | Incoming configuration word |
| dataValid | input | 1 | `dataIn` is valid |
| crcValid | input | 1 | Frame loader presents a CRC result |
| crcOk | input | 1 | CRC result: 1 match, 0 mismatch |
| loadDone | input | 1 | Frame loader finished the stream |
| memClear | output | 1 | Configuration memory clear strobe |
| initDriveLow | output | 1 | Pull the init line low (open-drain enable) |
| ioTristate | output | 1 | Hold user I/O in high impedance |
| cclkEn | output | 1 | Configuration clock is being driven |
| cclkOut | output | 1 | Generated configuration clock |
| cfgMode | output | 2 | Captured mode |
| cfgVariant | output | 1 | Captured variant (master flash modes only) |
| wordOut | output | WORD_W | Word handed to the frame loader |
| wordValid | output | 1 | `wordOut` is valid |

## Verification
Two things can happen in the same cycle during loading: a frame CRC mismatch and the loader's completion flag. The bench raises `crcValid` with `crcOk`=0 and `loadDone` on the same edge. It then expects abort signalling: the init line is driven low, the I/O stays tri-stated and the clock stops. The handoff pattern of R9 must not appear. The pattern is observed again 20 cycles later to show the abort holds.

// File: rtl/cfg_session_pkg.sv
package cfg_session_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_CLEAR,
    ST_INIT_WAIT,
    ST_LOAD,
    ST_ABORT,
    ST_HANDOFF
  } sess_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startClear;
    logic clearing;
    logic sampleMode;
    logic clkRun;
    logic passWords;
  } sess_ctrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic progLong;
    logic progHigh;
    logic clearDone;
    logic initHigh;
    logic isMaster;
  } sess_stat_t;

  localparam logic [1:0] MODE_MSTR_SER = 2'b00;
  localparam logic [1:0] MODE_MSTR_PAR = 2'b01;
  localparam logic [1:0] MODE_SLV_PAR  = 2'b10;
  localparam logic [1:0] MODE_SLV_SER  = 2'b11;

  function automatic logic modeIsMaster(input logic [1:0] m);
    return ~m[1];
  endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic stage1;
  logic stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RESET_VAL;
      stage2 <= RESET_VAL;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/cfg_session_dp.sv
module cfg_session_dp
  import cfg_session_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int MIN_PROG     = 8,
  parameter int CLEAR_CYCLES = 16,
  parameter int CCLK_HALF    = 2
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              progPinN,
  input  logic              initPinIn,
  input  logic [1:0]        modePins,
  input  logic              variantSel,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              dataValid,
  input  sess_ctrl_t        ctrl,
  output sess_stat_t        stat,
  output logic [1:0]        cfgMode,
  output logic              cfgVariant,
  output logic              cclkOut,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  localparam int PW = $clog2(MIN_PROG + 1);
  localparam int CW = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES) : 1;
  localparam int DW = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;
  localparam logic [PW-1:0] PROG_LIMIT = PW'(MIN_PROG);
  localparam logic [CW-1:0] CLEAR_LAST = CW'(CLEAR_CYCLES - 1);
  localparam logic [DW-1:0] DIV_LAST   = DW'(CCLK_HALF - 1);

  logic progSync;
  logic initSync;

  cfg_sync2 #(.RESET_VAL(1'b1)) uProgSync (
    .clk(clk), .rstN(pwrGood), .din(progPinN), .dout(progSync)
  );
  cfg_sync2 #(.RESET_VAL(1'b0)) uInitSync (
    .clk(clk), .rstN(pwrGood), .din(initPinIn), .dout(initSync)
  );

  // program pulse width filter
  logic [PW-1:0] lowCnt;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)          lowCnt <= '0;
    else if (progSync)     lowCnt <= '0;
    else if (lowCnt != PROG_LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  // clear phase length
  logic [CW-1:0] clrCnt;
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood)                          clrCnt <= '0;
    else if (ctrl.startClear)              clrCnt <= CLEAR_LAST;
    else if (ctrl.clearing && clrCnt != '0) clrCnt <= clrCnt - 1'b1;
  end

  // mode capture
  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      cfgMode    <= MODE_MSTR_SER;
      cfgVariant <= 1'b0;
    end else if (ctrl.sampleMode) begin
      cfgMode    <= modePins;
      cfgVariant <= variantSel & modeIsMaster(modePins);
    end
  end

  // configuration clock generator
  logic [DW-1:0] divCnt;
  logic          cclkReg;
  logic          divWrap;
  logic          cclkRise;

  assign divWrap  = (divCnt == DIV_LAST);
  assign cclkRise = ctrl.clkRun & divWrap & ~cclkReg;

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      divCnt  <= '0;
      cclkReg <= 1'b0;
    end else if (!ctrl.clkRun) begin
      divCnt  <= '0;
      cclkReg <= 1'b0;
    end else if (divWrap) begin
      divCnt  <= '0;
      cclkReg <= ~cclkReg;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end
  assign cclkOut = cclkReg;

  // word hand-off to the frame loader
  logic acceptWord;
  assign acceptWord = ctrl.passWords & dataValid &
                      (modeIsMaster(cfgMode) ? cclkRise : 1'b1);

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= acceptWord;
      if (acceptWord) wordOut <= dataIn;
    end
  end

  assign stat.progLong  = (lowCnt == PROG_LIMIT);
  assign stat.progHigh  = progSync;
  assign stat.clearDone = (clrCnt == '0);
  assign stat.initHigh  = initSync;
  assign stat.isMaster  = modeIsMaster(cfgMode);

  // R2
  prog_filter_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    stat.progLong |-> !$past(progSync));

  // R6
  idle_clk_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    !ctrl.clkRun |=> !cclkOut);

  // R7
  word_gate_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    wordValid |-> $past(ctrl.passWords && dataValid));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    !ctrl.sampleMode |=> $stable(cfgMode));

endmodule

// File: rtl/cfg_session_fsm.sv
module cfg_session_fsm
  import cfg_session_pkg::*;
(
  input  logic       clk,
  input  logic       pwrGood,
  input  logic       crcValid,
  input  logic       crcOk,
  input  logic       loadDone,
  input  sess_stat_t stat,
  output sess_ctrl_t ctrl,
  output logic       memClear,
  output logic       initDriveLow,
  output logic       ioTristate
);
  sess_state_e state;
  sess_state_e stateNext;
  logic        crcFail;

  assign crcFail = crcValid & ~crcOk;

  always_comb begin
    stateNext = state;
    if (stat.progLong) begin
      stateNext = ST_HOLD;
    end else begin
      unique case (state)
        ST_HOLD:      if (stat.progHigh)  stateNext = ST_CLEAR;
        ST_CLEAR:     if (stat.clearDone) stateNext = ST_INIT_WAIT;
        ST_INIT_WAIT: if (stat.initHigh)  stateNext = ST_LOAD;
        ST_LOAD: begin
          if (crcFail)       stateNext = ST_ABORT;
          else if (loadDone) stateNext = ST_HANDOFF;
        end
        ST_ABORT:     stateNext = ST_ABORT;
        ST_HANDOFF:   stateNext = ST_HANDOFF;
        default:      stateNext = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_HOLD;
    else          state <= stateNext;
  end

  always_comb begin
    ctrl.startClear = (state == ST_HOLD) & stat.progHigh & ~stat.progLong;
    ctrl.clearing   = (state == ST_CLEAR);
    ctrl.sampleMode = (state == ST_INIT_WAIT) & stat.initHigh & ~stat.progLong;
    ctrl.clkRun     = (state == ST_LOAD) & stat.isMaster;
    ctrl.passWords  = (state == ST_LOAD);
  end

  assign memClear     = (state == ST_CLEAR);
  assign initDriveLow = (state == ST_HOLD) | (state == ST_CLEAR) | (state == ST_ABORT);
  assign ioTristate   = (state != ST_HANDOFF);

  // R3
  clear_hold_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_CLEAR && !stat.clearDone && !stat.progLong) |=> state == ST_CLEAR);

  // R8
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_ABORT && !stat.progLong) |=> state == ST_ABORT);

  // R10
  crc_priority_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_LOAD && crcFail && !stat.progLong) |=> state == ST_ABORT);

  // R4
  init_stall_chk: assert property (@(posedge clk) disable iff (!pwrGood)
    (state == ST_INIT_WAIT && !stat.initHigh && !stat.progLong) |=> state == ST_INIT_WAIT);

endmodule

// File: rtl/cfg_session_ctrl.sv
module cfg_session_ctrl
  import cfg_session_pkg::*;
#(
  parameter int WORD_W       = 32,
  parameter int MIN_PROG     = 8,
  parameter int CLEAR_CYCLES = 16,
  parameter int CCLK_HALF    = 2
) (
  input  logic              clk,
  input  logic              pwrGood,
  input  logic              progPinN,
  input  logic              initPinIn,
  input  logic [1:0]        modePins,
  input  logic              variantSel,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              dataValid,
  input  logic              crcValid,
  input  logic              crcOk,
  input  logic              loadDone,
  output logic              memClear,
  output logic              initDriveLow,
  output logic              ioTristate,
  output logic              cclkEn,
  output logic              cclkOut,
  output logic [1:0]        cfgMode,
  output logic              cfgVariant,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  sess_ctrl_t ctrl;
  sess_stat_t stat;

  cfg_session_fsm uFsm (
    .clk(clk), .pwrGood(pwrGood), .crcValid(crcValid), .crcOk(crcOk),
    .loadDone(loadDone), .stat(stat), .ctrl(ctrl), .memClear(memClear),
    .initDriveLow(initDriveLow), .ioTristate(ioTristate)
  );

  cfg_session_dp #(
    .WORD_W(WORD_W), .MIN_PROG(MIN_PROG),
    .CLEAR_CYCLES(CLEAR_CYCLES), .CCLK_HALF(CCLK_HALF)
  ) uDp (
    .clk(clk), .pwrGood(pwrGood), .progPinN(progPinN), .initPinIn(initPinIn),
    .modePins(modePins), .variantSel(variantSel), .dataIn(dataIn),
    .dataValid(dataValid), .ctrl(ctrl), .stat(stat), .cfgMode(cfgMode),
    .cfgVariant(cfgVariant), .cclkOut(cclkOut), .wordOut(wordOut),
    .wordValid(wordValid)
  );

  assign cclkEn = ctrl.clkRun;

endmodule

// File: tb/tb_cfg_session_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_session_ctrl;
  localparam int WORD_W       = 32;
  localparam int MIN_PROG     = 8;
  localparam int CLEAR_CYCLES = 16;
  localparam int CCLK_HALF    = 2;

  logic clk = 1'b0;
  logic pwrGood = 1'b0;
  logic progPinN = 1'b1;
  logic extHold = 1'b0;
  logic initPinIn;
  logic [1:0] modePins = 2'b00;
  logic variantSel = 1'b0;
  logic [WORD_W-1:0] dataIn = '0;
  logic dataValid = 1'b0;
  logic crcValid = 1'b0;
  logic crcOk = 1'b1;
  logic loadDone = 1'b0;
  logic memClear, initDriveLow, ioTristate, cclkEn, cclkOut, cfgVariant, wordValid;
  logic [1:0] cfgMode;
  logic [WORD_W-1:0] wordOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // open-drain init line with pull-up
  assign initPinIn = ~(initDriveLow | extHold);

  cfg_session_ctrl #(
    .WORD_W(WORD_W), .MIN_PROG(MIN_PROG),
    .CLEAR_CYCLES(CLEAR_CYCLES), .CCLK_HALF(CCLK_HALF)
  ) dut (
    .clk(clk), .pwrGood(pwrGood), .progPinN(progPinN), .initPinIn(initPinIn),
    .modePins(modePins), .variantSel(variantSel), .dataIn(dataIn),
    .dataValid(dataValid), .crcValid(crcValid), .crcOk(crcOk), .loadDone(loadDone),
    .memClear(memClear), .initDriveLow(initDriveLow), .ioTristate(ioTristate),
    .cclkEn(cclkEn), .cclkOut(cclkOut), .cfgMode(cfgMode), .cfgVariant(cfgVariant),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic progPulse(input int lowCycles);
    progPinN = 1'b0;
    tick(lowCycles);
    progPinN = 1'b1;
  endtask

  // waits for the clear phase and measures it
  task automatic measureClear(input string req);
    int len = 0;
    int guard = 0;
    bit sideOk = 1'b1;
    while (!memClear && guard < 60) begin tick(1); guard++; end
    check(req, "clear phase seen", memClear, 1);
    while (memClear && len < 200) begin
      if (!initDriveLow || !ioTristate) sideOk = 1'b0;
      len++;
      tick(1);
    end
    check(req, "clear length", len, CLEAR_CYCLES);
    check(req, "init low and io tristate while clearing", sideOk, 1);
  endtask

  task automatic testReset();
    tick(2);
    check("R1", "initDriveLow in reset", initDriveLow, 1);
    check("R1", "ioTristate in reset", ioTristate, 1);
    check("R1", "memClear in reset", memClear, 0);
    check("R1", "cclkEn in reset", cclkEn, 0);
    check("R1", "wordValid in reset", wordValid, 0);
  endtask

  task automatic testPowerUpMaster();
    modePins = 2'b00; variantSel = 1'b1;
    pwrGood = 1'b1;
    measureClear("R3");
    check("R4", "init released after clear", initDriveLow, 0);
    tick(6);
    check("R5", "mode master serial", cfgMode, 2'b00);
    check("R5", "variant honoured in master serial", cfgVariant, 1);
    check("R6", "cclkEn in master", cclkEn, 1);
    begin
      int toggles = 0;
      logic prevClk = cclkOut;
      logic [WORD_W-1:0] prevData;
      int badWord = 0;
      int words = 0;
      dataValid = 1'b1;
      for (int i = 0; i < 40; i++) begin
        prevData = dataIn + 32'h11;
        dataIn = prevData;
        tick(1);
        if (cclkOut != prevClk) toggles++;
        if (wordValid != (cclkOut && !prevClk)) badWord++;
        if (wordValid) begin
          words++;
          if (wordOut != prevData) badWord++;
        end
        prevClk = cclkOut;
      end
      dataValid = 1'b0;
      check("R6", "cclk toggles in 40 cycles", toggles, 40 / CCLK_HALF);
      check("R7", "master words only on cclk rise", badWord, 0);
      check("R7", "master word count", words, 40 / (2 * CCLK_HALF));
    end
  endtask

  task automatic testCrcVsDone();
    // R10: CRC mismatch and loadDone in the same cycle
    crcValid = 1'b1; crcOk = 1'b0; loadDone = 1'b1;
    tick(1);
    crcValid = 1'b0; crcOk = 1'b1; loadDone = 1'b0;
    check("R10", "abort wins: initDriveLow", initDriveLow, 1);
    check("R10", "abort wins: ioTristate", ioTristate, 1);
    check("R8", "clock stops on abort", cclkEn, 0);
    dataValid = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin tick(1); if (wordValid) seen++; end
      check("R8", "no words after abort", seen, 0);
    end
    dataValid = 1'b0;
    check("R8", "abort persists", initDriveLow, 1);
  endtask

  task automatic testShortPulse();
    int cleared = 0;
    progPulse(MIN_PROG - 1);
    for (int i = 0; i < 20; i++) begin tick(1); if (memClear) cleared++; end
    check("R2", "short program pulse ignored", cleared, 0);
    check("R2", "still aborted after short pulse", initDriveLow, 1);
  endtask

  task automatic testStallAndSlave();
    modePins = 2'b01; variantSel = 1'b1;
    progPulse(MIN_PROG);
    extHold = 1'b1;
    measureClear("R2");
    tick(30);
    check("R4", "no clock while held", cclkEn, 0);
    check("R4", "mode not captured while held", cfgMode, 2'b00);
    check("R4", "controller not driving init", initDriveLow, 0);
    modePins = 2'b11; variantSel = 1'b1;
    extHold = 1'b0;
    tick(6);
    check("R5", "mode slave serial captured", cfgMode, 2'b11);
    check("R5", "variant ignored in slave", cfgVariant, 0);
    check("R6", "no cclk in slave", cclkEn, 0);
    check("R6", "cclkOut low in slave", cclkOut, 0);
    for (int i = 0; i < 10; i++) begin
      logic v = (i % 3) != 0;
      logic [WORD_W-1:0] d = 32'hA500_0000 + i;
      dataValid = v; dataIn = d;
      tick(1);
      check("R7", "slave wordValid", wordValid, v);
      if (v) check("R7", "slave wordOut", wordOut, d);
    end
    dataValid = 1'b0;
    loadDone = 1'b1;
    tick(1);
    loadDone = 1'b0;
    check("R9", "io released on done", ioTristate, 0);
    check("R9", "clock off on done", cclkEn, 0);
    check("R9", "init not driven on done", initDriveLow, 0);
  endtask

  task automatic testVariantAndPower();
    modePins = 2'b01; variantSel = 1'b1;
    progPulse(MIN_PROG + 3);
    measureClear("R3");
    tick(6);
    check("R5", "variant honoured in master parallel", cfgVariant, 1);
    check("R6", "cclkEn in master parallel", cclkEn, 1);
    modePins = 2'b10; variantSel = 1'b1;
    progPulse(MIN_PROG);
    measureClear("R2");
    tick(6);
    check("R5", "mode slave parallel", cfgMode, 2'b10);
    check("R5", "variant ignored in slave parallel", cfgVariant, 0);
    // R1: asynchronous power drop while loading
    modePins = 2'b00;
    progPulse(MIN_PROG);
    measureClear("R3");
    tick(6);
    check("R6", "clock running before power drop", cclkEn, 1);
    #3 pwrGood = 1'b0;
    #1;
    check("R1", "power drop: init driven", initDriveLow, 1);
    check("R1", "power drop: clock off", cclkEn, 0);
    check("R1", "power drop: io tristate", ioTristate, 1);
  endtask

  initial begin
    testReset();
    testPowerUpMaster();
    testCrcVsDone();
    testShortPulse();
    testStallAndSlave();
    testVariantAndPower();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule